// File: doc/BRIEF.md
# Indexed Addressing Effective-Address Unit

This block turns an indexed-addressing postbyte, plus up to two extension bytes, into a 16-bit effective address. It selects a base register and adds an offset to it. The offset can be a short constant, a sign-extended constant built from the extension bytes, or an accumulator. The auto-modify forms also produce an updated copy of the base register, which goes out on a write-back port. The two indirect forms do not use the sum as the result. They use it as the address of a 16-bit pointer, fetch that pointer over a simple request/valid read port, and report the pointer as the final address.

The surrounding core raises `start_i` for one cycle. During that cycle the postbyte, the extension bytes, the index registers and the accumulators must all be valid. The unit then reports the address, the number of extension bytes the form consumed, and any write-back. All of these are registered and appear on the cycle where `done_o` pulses. The PC input must already point past the last extension byte.

Top module: `idx_ea_unit`

## Requirements
- R1: The 2-bit register field selects the base: 00 = X, 01 = Y, 10 = SP, 11 = PC. The field is postbyte bits 7:6 when bits 7:5 are not 111, and bits 4:3 otherwise.
- R2: Postbyte `rr0nnnnn` adds the 5-bit two's complement value nnnnn (-16..+15) to the base. It reports 0 extension bytes.
- R3: Postbyte `111rr00s` adds the 9-bit signed value {s, ext0}, where s is postbyte bit 0. It reports 1 extension byte.
- R4: Postbyte `111rr010` adds the 16-bit value {ext0, ext1}, with ext0 as the high byte. It reports 2 extension bytes.
- R5: Postbyte `rr1pnnnn` is auto-modify. Codes nnnn 0000..0111 mean +1..+8 and codes 1000..1111 mean -8..-1. With p=0 the address is base+adj; with p=1 the address is the unmodified base. In both cases the write-back carries base+adj and `wb_sel_o` = rr. The form reports 0 extension bytes.
- R6: Write-back is strobed only for auto-modify and never targets PC. Any postbyte whose top three bits are 111 decodes as one of the extended forms, so auto-modify cannot select PC.
- R7: Postbyte `111rr1aa` with aa=00 adds A zero-extended, with aa=01 adds B zero-extended, and with aa=10 adds D = {A, B}, A being the high byte. It reports 0 extension bytes.
- R8: Postbyte `111rr011` requests a read at base+{ext0,ext1}. The returned data becomes the address, and the form reports 2 extension bytes.
- R9: Postbyte `111rr111` requests a read at base+{A,B}. The returned data becomes the address, and the form reports 0 extension bytes.
- R10: For the non-indirect forms, `done_o` pulses for one cycle on the cycle after `start_i`. For the indirect forms, `rd_req_o` holds with a stable address until `rd_valid_i` is seen, and `done_o` pulses on the following cycle with `rd_req_o` low.
- R11: After reset, `done_o`, `rd_req_o` and `wb_valid_o` are 0 and `ea_o` is 0. A `start_i` that arrives while a read is pending does not change the result.
- R12: Every addition wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one address computation |
| postbyte_i | input | 8 | Indexed-mode postbyte |
| ext0_i | input | 8 | First extension byte |
| ext1_i | input | 8 | Second extension byte |
| x_i | input | 16 | X index register |
| y_i | input | 16 | Y index register |
| sp_i | input | 16 | Stack pointer |
| pc_i | input | 16 | PC, pointing past the last extension byte |
| a_i | input | 8 | Accumulator A |
| b_i | input | 8 | Accumulator B |
| rd_req_o | output | 1 | Pointer read request |
| rd_addr_o | output | 16 | Pointer read address |
| rd_valid_i | input | 1 | Pointer read data valid |
| rd_data_i | input | 16 | Pointer read data |
| done_o | output | 1 | Result valid, one-cycle pulse |
| ea_o | output | 16 | Effective address |
| ext_cnt_o | output | 2 | Extension bytes consumed |
| wb_valid_o | output | 1 | Index write-back strobe |
| wb_sel_o | output | 2 | Register being written back (rr code) |
| wb_data_o | output | 16 | Updated register value |

## Verification
Random postbytes cover every form and all four base registers, with random register and accumulator values. This separates the base-select path from the offset path. It also exposes sign-extension errors in the 5-bit, 9-bit and auto-modify offsets, because negative offsets land on bases near zero. Directed cases fix the extremes: -16 and +15, -8 and +8, and pre versus post modify on the same register. They also fix A versus B versus D, so that a swapped byte order or a missing zero-extension stands out. Indirect reads use random response latencies and sometimes a stray start pulse during the wait, which separates the address that was requested from the data that was returned.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  typedef enum logic [2:0] {
    M_C5, M_C9, M_C16, M_I16, M_AUTO, M_ACC, M_IACC
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic [1:0] rr;
    logic [4:0] n5;
    logic [3:0] n4;
    logic       pre;
    logic [1:0] acc;
    logic       sgn9;
    logic [1:0] ext_cnt;
    logic       indirect;
    logic       wb_en;
  } dec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_DONE} state_e;

  localparam logic [1:0] RR_X  = 2'b00;
  localparam logic [1:0] RR_Y  = 2'b01;
  localparam logic [1:0] RR_SP = 2'b10;
  localparam logic [1:0] RR_PC = 2'b11;
endpackage

// File: rtl/idx_postbyte_decode.sv
module idx_postbyte_decode
  import idx_ea_pkg::*;
(
  input  logic [7:0] postbyte_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.mode = M_C5;
    dec_o.n5   = postbyte_i[4:0];
    dec_o.n4   = postbyte_i[3:0];
    dec_o.pre  = ~postbyte_i[4];
    dec_o.acc  = postbyte_i[1:0];
    dec_o.sgn9 = postbyte_i[0];
    if (postbyte_i[7:5] != 3'b111) begin
      dec_o.rr = postbyte_i[7:6];
      if (postbyte_i[5]) begin
        // rr==PC here would need prefix 111, so it never reaches this branch
        dec_o.mode  = M_AUTO;
        dec_o.wb_en = 1'b1;
      end
    end else begin
      dec_o.rr = postbyte_i[4:3];
      if (!postbyte_i[2]) begin
        unique case (postbyte_i[1:0])
          2'b00, 2'b01: begin dec_o.mode = M_C9;  dec_o.ext_cnt = 2'd1; end
          2'b10:        begin dec_o.mode = M_C16; dec_o.ext_cnt = 2'd2; end
          default: begin
            dec_o.mode     = M_I16;
            dec_o.ext_cnt  = 2'd2;
            dec_o.indirect = 1'b1;
          end
        endcase
      end else if (postbyte_i[1:0] == 2'b11) begin
        dec_o.mode     = M_IACC;
        dec_o.indirect = 1'b1;
      end else begin
        dec_o.mode = M_ACC;
      end
    end
  end
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int AW    = 2 * BYTE_W
) (
  input  dec_t              dec_i,
  input  logic [BYTE_W-1:0] ext0_i,
  input  logic [BYTE_W-1:0] ext1_i,
  input  logic [AW-1:0]     x_i,
  input  logic [AW-1:0]     y_i,
  input  logic [AW-1:0]     sp_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     wb_data_o
);
  logic [AW-1:0] base, offs, adj;

  always_comb begin
    unique case (dec_i.rr)
      RR_X:    base = x_i;
      RR_Y:    base = y_i;
      RR_SP:   base = sp_i;
      default: base = pc_i;
    endcase
  end

  // two's complement code, non-negative codes shifted up by one
  assign adj = dec_i.n4[3] ? {{(AW-4){1'b1}}, dec_i.n4}
                           : {{(AW-4){1'b0}}, dec_i.n4} + AW'(1);

  always_comb begin
    unique case (dec_i.mode)
      M_C5:    offs = {{(AW-5){dec_i.n5[4]}}, dec_i.n5};
      M_C9:    offs = {{(AW-BYTE_W){dec_i.sgn9}}, ext0_i};
      M_C16,
      M_I16:   offs = {ext0_i, ext1_i};
      M_AUTO:  offs = dec_i.pre ? adj : '0;
      M_ACC: begin
        unique case (dec_i.acc)
          2'b00:   offs = {{(AW-BYTE_W){1'b0}}, a_i};
          2'b01:   offs = {{(AW-BYTE_W){1'b0}}, b_i};
          default: offs = {a_i, b_i};
        endcase
      end
      default: offs = {a_i, b_i};
    endcase
  end

  assign addr_o    = base + offs;
  assign wb_data_o = base + adj;
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int AW    = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        postbyte_i,
  input  logic [BYTE_W-1:0] ext0_i,
  input  logic [BYTE_W-1:0] ext1_i,
  input  logic [AW-1:0]     x_i,
  input  logic [AW-1:0]     y_i,
  input  logic [AW-1:0]     sp_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [AW-1:0]     rd_data_i,
  output logic              done_o,
  output logic [AW-1:0]     ea_o,
  output logic [1:0]        ext_cnt_o,
  output logic              wb_valid_o,
  output logic [1:0]        wb_sel_o,
  output logic [AW-1:0]     wb_data_o
);
  dec_t          dec;
  logic [AW-1:0] calc_addr, calc_wb;
  state_e        state_q;
  logic [AW-1:0] ea_q, rd_addr_q, wb_data_q;
  logic [1:0]    ext_q, wb_sel_q;
  logic          wb_pend_q;

  idx_postbyte_decode u_dec (
    .postbyte_i (postbyte_i),
    .dec_o      (dec)
  );

  idx_ea_calc #(.BYTE_W(BYTE_W)) u_calc (
    .dec_i     (dec),
    .ext0_i    (ext0_i),
    .ext1_i    (ext1_i),
    .x_i       (x_i),
    .y_i       (y_i),
    .sp_i      (sp_i),
    .pc_i      (pc_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .addr_o    (calc_addr),
    .wb_data_o (calc_wb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ea_q      <= '0;
      rd_addr_q <= '0;
      wb_data_q <= '0;
      ext_q     <= '0;
      wb_sel_q  <= '0;
      wb_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ext_q     <= dec.ext_cnt;
          wb_sel_q  <= dec.rr;
          wb_data_q <= calc_wb;
          wb_pend_q <= dec.wb_en;
          if (dec.indirect) begin
            rd_addr_q <= calc_addr;
            state_q   <= ST_READ;
          end else begin
            ea_q    <= calc_addr;
            state_q <= ST_DONE;
          end
        end
        ST_READ: if (rd_valid_i) begin
          ea_q    <= rd_data_i;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = (state_q == ST_DONE);
  assign rd_req_o   = (state_q == ST_READ);
  assign rd_addr_o  = rd_addr_q;
  assign ea_o       = ea_q;
  assign ext_cnt_o  = ext_q;
  assign wb_valid_o = done_o & wb_pend_q;
  assign wb_sel_o   = wb_sel_q;
  assign wb_data_o  = wb_data_q;

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));
  p_ptr_result_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_valid_i) |=> (done_o && !rd_req_o && ea_o == $past(rd_data_i)));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_wb_not_pc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (wb_sel_o != RR_PC));
  p_busy_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && start_i && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));
  p_ext_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ext_cnt_o != 2'd3));
endmodule

// File: tb/idx_ea_unit_tb.sv
module idx_ea_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  pb = '0, e0 = '0, e1 = '0, ra = '0, rb = '0;
  logic [15:0] rx = '0, ry = '0, rsp = '0, rpc = '0;
  logic        rd_req, rd_valid = 1'b0, done, wb_valid;
  logic [15:0] rd_addr, rd_data = '0, ea, wb_data;
  logic [1:0]  ext_cnt, wb_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ea_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .postbyte_i(pb),
    .ext0_i(e0), .ext1_i(e1), .x_i(rx), .y_i(ry), .sp_i(rsp), .pc_i(rpc),
    .a_i(ra), .b_i(rb), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .done_o(done), .ea_o(ea),
    .ext_cnt_o(ext_cnt), .wb_valid_o(wb_valid), .wb_sel_o(wb_sel),
    .wb_data_o(wb_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pb=%02h act=%0h exp=%0h", req, pb, act, exp);
    end
  endtask

  function automatic logic [15:0] base_of(input logic [1:0] r);
    case (r)
      2'b00: return rx;
      2'b01: return ry;
      2'b10: return rsp;
      default: return rpc;
    endcase
  endfunction

  // reference model written from the requirements
  task automatic model(output logic [15:0] addr, output logic ind, output logic [1:0] ext,
                       output logic wbv, output logic [15:0] wbd, output logic [1:0] r,
                       output string req);
    int v;
    logic [15:0] bs, adj;
    ind = 0; ext = 0; wbv = 0; wbd = 0;
    if (pb[7:5] != 3'b111) begin
      r = pb[7:6]; bs = base_of(r);
      if (!pb[5]) begin
        v = (pb[4:0] > 15) ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
        addr = bs + 16'(v); req = "R2";
      end else begin
        v = int'(pb[3:0]);
        adj = (v < 8) ? 16'(v + 1) : 16'(v - 16);
        wbv = 1; wbd = bs + adj;
        addr = pb[4] ? bs : bs + adj; req = "R5";
      end
    end else begin
      r = pb[4:3]; bs = base_of(r);
      case (pb[2:0])
        3'b000, 3'b001: begin
          addr = bs + (pb[0] ? {8'hFF, e0} : {8'h00, e0}); ext = 1; req = "R3";
        end
        3'b010: begin addr = bs + {e0, e1}; ext = 2; req = "R4"; end
        3'b011: begin addr = bs + {e0, e1}; ext = 2; ind = 1; req = "R8"; end
        3'b100: begin addr = bs + {8'h00, ra}; req = "R7"; end
        3'b101: begin addr = bs + {8'h00, rb}; req = "R7"; end
        3'b110: begin addr = bs + {ra, rb}; req = "R7"; end
        default: begin addr = bs + {ra, rb}; ind = 1; req = "R9"; end
      endcase
    end
  endtask

  task automatic run_op(input int lat, input logic [15:0] pdata, input logic poke);
    logic [15:0] addr, wbd;
    logic ind, wbv;
    logic [1:0] ext, r;
    string req;
    model(addr, ind, ext, wbv, wbd, r, req);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (!ind) begin
      chk("R10 done", done, 1);
      chk(req, ea, addr);
    end else begin
      chk("R10 req", {rd_req, done}, 2'b10);
      chk(req, rd_addr, addr);
      if (poke) begin start = 1'b1; pb = pb ^ 8'h5A; rx = ~rx; end
      for (int i = 0; i < lat; i++) begin
        @(negedge clk); start = 1'b0;
        chk("R10 wait", {rd_req, done}, 2'b10);
        chk("R11 busy", rd_addr, addr);
      end
      rd_valid = 1'b1; rd_data = pdata;
      @(negedge clk); rd_valid = 1'b0; start = 1'b0;
      chk("R10 ptr done", {rd_req, done}, 2'b01);
      chk(req, ea, pdata);
    end
    chk(ind ? "R8/R9 ext" : "R4 ext", ext_cnt, ext);
    chk("R6 wb", wb_valid, wbv);
    if (wbv) begin
      chk("R5 wb data", wb_data, wbd);
      chk("R1 wb sel", wb_sel, r);
      chk("R6 not pc", wb_sel != 2'b11, 1);
    end
    @(negedge clk);
    chk("R10 pulse", done, 0);
  endtask

  task automatic set_regs(input logic [15:0] x, y, s, p, input logic [7:0] a, b);
    rx = x; ry = y; rsp = s; rpc = p; ra = a; rb = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1DEA5));
    repeat (2) @(negedge clk);
    chk("R11 reset", {done, rd_req, wb_valid}, 3'b000);
    chk("R11 reset ea", ea, 0);
    rst_n = 1'b1;

    set_regs(16'h0005, 16'h1000, 16'h2000, 16'h3000, 8'h12, 8'hF0);
    pb = 8'h10; run_op(0, 0, 0);                    // R2 -16, wraps R12
    pb = 8'h4F; run_op(0, 0, 0);                    // R2 +15 on Y
    pb = 8'hC1; run_op(0, 0, 0);                    // R1 PC base
    pb = 8'h37; run_op(0, 0, 0);                    // R5 post +8 on X
    pb = 8'hA8; run_op(0, 0, 0);                    // R5 pre -8 on SP
    pb = 8'h28; run_op(0, 0, 0);                    // R5 pre -8 on X, wraps R12
    pb = 8'hE9; e0 = 8'h80; run_op(0, 0, 0);        // R3 negative 9-bit
    pb = 8'hF2; e0 = 8'hAB; e1 = 8'hCD; run_op(0, 0, 0); // R4 on SP
    pb = 8'hE4; run_op(0, 0, 0);                    // R7 A
    pb = 8'hE5; run_op(0, 0, 0);                    // R7 B
    pb = 8'hE6; run_op(0, 0, 0);                    // R7 D
    pb = 8'hFB; run_op(2, 16'hBEEF, 1);             // R8 on PC, busy start R11
    pb = 8'hEF; run_op(0, 16'h1234, 0);             // R9 on Y

    for (int k = 0; k < 400; k++) begin
      pb = 8'($urandom); e0 = 8'($urandom); e1 = 8'($urandom);
      set_regs(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
               8'($urandom), 8'($urandom));
      run_op(int'($urandom % 4), 16'($urandom), 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule